// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block generates the address for each beat of a four-beat burst on a synchronous memory port. A new access loads a full external address. Each later advance cycle moves the two low address bits to the next beat. The bits above them keep the value captured at the load.

A static order-select input picks one of two orderings. The linear order adds the beat count to the starting low bits, modulo four. The interleaved order XORs the starting low bits with the beat count. In both orders the fifth position wraps back to the starting address.

A freeze input makes the sequencer ignore every other input and keep its state. Every decision is taken on the rising clock edge, and both outputs come straight from registers.

Top module: `burst_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `burst_addr` = 0 and `beat_idx` = 0.
- R2: When `freeze` = 0 and `adv` = 0 at an edge, after that edge `burst_addr` equals the sampled `load_addr` and `beat_idx` = 0.
- R3: When `freeze` = 0 and `adv` = 1 at an edge, `beat_idx` increases by one modulo 4 (3 goes to 0).
- R4: With `ilv_sel` = 0 (linear), the low two bits of `burst_addr` equal (start + `beat_idx`) mod 4, where start is the low two bits of the last loaded address.
- R5: With `ilv_sel` = 1 (interleaved), the low two bits of `burst_addr` equal start XOR `beat_idx`.
- R6: Advancing never changes `burst_addr` bits above bit 1.
- R7: After four advances from a load, `burst_addr` is again the loaded address and `beat_idx` is 0.
- R8: While `freeze` = 1, `adv`, `ilv_sel` and `load_addr` have no effect, and `burst_addr` and `beat_idx` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| freeze | input | 1 | 1 = ignore all other inputs and hold state |
| adv | input | 1 | 0 = load `load_addr`, 1 = step to the next beat |
| ilv_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| load_addr | input | ADDR_W | External start address |
| burst_addr | output | ADDR_W | Registered address of the current beat |
| beat_idx | output | CNT_W | Registered beat count since the last load |

## Verification
The assertions assume that reset is high from time zero and that every input carries a known value at each edge. Under that assumption, each step's low bits follow from the previous output and the previous beat count. The bench drives only known values, holds reset for several cycles, and changes `ilv_sel` only on the cycle of a load, so every burst runs in one order. One directed case changes `ilv_sel` while `freeze` is high, to show that it is ignored.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  output logic [CNT_W-1:0] beat_q,
  output logic [CNT_W-1:0] beat_nxt
);
  assign beat_nxt = beat_q + {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)       beat_q <= '0;
    else if (load) beat_q <= '0;
    else if (step) beat_q <= beat_nxt;
  end
endmodule

// File: rtl/bsq_order.sv
module bsq_order
  import bsq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start,
  input  logic [CNT_W-1:0] beat,
  input  order_e           order,
  output logic [CNT_W-1:0] low
);
  logic [CNT_W-1:0] lin_low;
  logic [CNT_W-1:0] ilv_low;

  assign lin_low = start + beat;

  for (genvar b = 0; b < CNT_W; b++) begin : g_xor
    assign ilv_low[b] = start[b] ^ beat[b];
  end

  always_comb begin
    unique case (order)
      ORD_INTERLEAVE: low = ilv_low;
      default:        low = lin_low;
    endcase
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import bsq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              freeze,
  input  logic              adv,
  input  logic              ilv_sel,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [CNT_W-1:0]  beat_idx
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic             do_load;
  logic             do_step;
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] beat_nxt;
  logic [CNT_W-1:0] step_low;
  logic [HI_W-1:0]  hi_q;
  logic [CNT_W-1:0] low_q;
  order_e           order;

  assign do_load = !freeze && !adv;
  assign do_step = !freeze && adv;
  assign order   = order_e'(ilv_sel);

  bsq_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (do_load),
    .step     (do_step),
    .beat_q   (beat_idx),
    .beat_nxt (beat_nxt)
  );

  bsq_order #(.CNT_W(CNT_W)) u_ord (
    .start (start_q),
    .beat  (beat_nxt),
    .order (order),
    .low   (step_low)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      hi_q    <= '0;
      low_q   <= '0;
    end else if (do_load) begin
      start_q <= load_addr[CNT_W-1:0];
      hi_q    <= load_addr[ADDR_W-1:CNT_W];
      low_q   <= load_addr[CNT_W-1:0];
    end else if (do_step) begin
      low_q   <= step_low;
    end
  end

  assign burst_addr = {hi_q, low_q};
endmodule

// File: rtl/bsq_chk.sv
module bsq_chk #(
  parameter int ADDR_W = 19,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              freeze,
  input logic              adv,
  input logic              ilv_sel,
  input logic [ADDR_W-1:0] load_addr,
  input logic [ADDR_W-1:0] burst_addr,
  input logic [CNT_W-1:0]  beat_idx
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (burst_addr == '0 && beat_idx == '0));

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!freeze && !adv) |=> (burst_addr == $past(load_addr) && beat_idx == '0));

  // R3 R7
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!freeze && adv) |=> beat_idx == CNT_W'($past(beat_idx) + 1'b1));

  // R4
  linear_order_chk: assert property (@(posedge clk) disable iff (rst)
    (!freeze && adv && !ilv_sel) |=>
      burst_addr[CNT_W-1:0] == CNT_W'($past(burst_addr[CNT_W-1:0]) + 1'b1));

  // R5
  interleave_order_chk: assert property (@(posedge clk) disable iff (rst)
    (!freeze && adv && ilv_sel) |=>
      burst_addr[CNT_W-1:0] == ($past(burst_addr[CNT_W-1:0]) ^
        ($past(beat_idx) ^ CNT_W'($past(beat_idx) + 1'b1))));

  // R6
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!freeze && adv) |=> $stable(burst_addr[ADDR_W-1:CNT_W]));

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    freeze |=> ($stable(burst_addr) && $stable(beat_idx)));
endmodule

bind burst_seq bsq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .freeze     (freeze),
  .adv        (adv),
  .ilv_sel    (ilv_sel),
  .load_addr  (load_addr),
  .burst_addr (burst_addr),
  .beat_idx   (beat_idx)
);

// File: tb/burst_seq_tb.sv
module burst_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 19;
  localparam int CNT_W  = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              freeze = 1'b0;
  logic              adv = 1'b0;
  logic              ilv_sel = 1'b0;
  logic [ADDR_W-1:0] load_addr = '0;
  logic [ADDR_W-1:0] burst_addr;
  logic [CNT_W-1:0]  beat_idx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .freeze(freeze), .adv(adv), .ilv_sel(ilv_sel),
    .load_addr(load_addr), .burst_addr(burst_addr), .beat_idx(beat_idx)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [ADDR_W-1:0] exp_a,
                       input logic [CNT_W-1:0] exp_b);
    checks++;
    if (burst_addr !== exp_a || beat_idx !== exp_b) begin
      failures++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, burst_addr, beat_idx, exp_a, exp_b);
    end
  endtask

  function automatic logic [ADDR_W-1:0] expect_addr(input logic [ADDR_W-1:0] base,
      input bit ilv, input int k);
    int s;
    int lo;
    s  = int'(base[1:0]);
    lo = ilv ? (s ^ (k % 4)) : ((s + k) % 4);
    return {base[ADDR_W-1:2], 2'(lo)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] held_a;
    logic [CNT_W-1:0]  held_b;
    @(negedge clk);
    repeat (3) tick();
    check("R1 reset", '0, '0);
    rst = 1'b0;

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        base = {17'(32'h0A5A5 + 32'(m * 977 + s * 131)), 2'(s)};
        load_addr = base;
        ilv_sel = m[0];
        adv = 1'b0;
        tick();
        check("R2 load", base, '0);
        load_addr = ~base;
        adv = 1'b1;
        for (int k = 1; k <= 4; k++) begin
          tick();
          if (k == 4) check("R7 wrap", base, '0);
          else if (m == 0) check("R4 R6 R3 linear step", expect_addr(base, 1'b0, k), 2'(k));
          else check("R5 R6 R3 interleave step", expect_addr(base, 1'b1, k), 2'(k));
        end
        tick();
        check(m == 0 ? "R4 second lap" : "R5 second lap", expect_addr(base, m[0], 1), 2'd1);
      end
    end

    base = 19'h12346;
    ilv_sel = 1'b1;
    adv = 1'b0;
    load_addr = base;
    tick();
    adv = 1'b1;
    tick();
    held_a = burst_addr;
    held_b = beat_idx;
    check("R5 before freeze", expect_addr(base, 1'b1, 1), 2'd1);
    freeze = 1'b1;
    adv = 1'b1;
    repeat (3) tick();
    check("R8 freeze during steps", held_a, held_b);
    adv = 1'b0;
    load_addr = 19'h7FFFF;
    ilv_sel = 1'b0;
    repeat (2) tick();
    check("R8 freeze blocks load", held_a, held_b);
    freeze = 1'b0;
    ilv_sel = 1'b1;
    adv = 1'b1;
    tick();
    check("R8 resume after freeze", expect_addr(base, 1'b1, 2), 2'd2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule